// File: doc/BRIEF.md
# FM Tone Sequencer with Byte-Wide Synthesizer Loader

This block drives an external direct digital synthesizer so that its output carries a frequency-modulated 1kHz test tone. A sample timer fires twenty times per tone period, which is every 50µs at the default settings. On each firing the block reads the next entry of a twenty-point signed sine table. It scales that entry by the peak deviation of the selected mode and adds the result to the carrier tuning word. The resulting 40-bit control word is then pushed out as five bytes on an 8-bit port. Each byte has its own load strobe, and a final update pulse makes the synthesizer switch to the new frequency in a single step.

When modulation is off, the block sends the plain carrier word only when there is something new to send: once after reset, and again each time the carrier input changes. A stretched reset output holds the synthesizer in reset for a programmable number of cycles after the block leaves reset. A sample that comes due while a transfer is still running is skipped. The phase of the tone still advances, so the tone keeps its pitch.

Top module: `fm_dds_sequencer`

## Requirements
- R1: While rst_ni is low, dds_rst_o is 1 and dds_data_o, dds_wr_o and dds_fq_ud_o are 0. After release, dds_rst_o stays 1 for exactly RST_CYCLES cycles. No strobe or update pulse appears while dds_rst_o is 1.
- R2: A word goes out as five bytes. The CTRL_BYTE parameter comes first, then tuning word bits [31:24], [23:16], [15:8] and [7:0]. Each byte is on dds_data_o for one cycle with dds_wr_o low, then for one cycle with dds_wr_o high. The data does not change at the rising edge of dds_wr_o.
- R3: Exactly five dds_wr_o pulses precede each dds_fq_ud_o pulse. dds_fq_ud_o is high for one cycle and never at the same time as dds_wr_o.
- R4: The load strobes of one word come every second cycle. The update pulse comes exactly 9 cycles after the first strobe of that word.
- R5: While mod_en_i is high, a new word is sent every SAMPLE_DIV cycles, as long as each transfer (11 cycles) fits inside that interval.
- R6: The k-th sample after mod_en_i rises (k counted from 0, wrapping at 20) sends the tuning word carrier + floor(S[k]*D/1024) mod 2^32. Here S[k] = round(1024*sin(2*pi*k/20)) and D is the deviation constant of the mode.
- R7: dev_mode_i selects D. 2'b00 gives DEV_NB (default 51540, about 1.5kHz at a 125MHz reference). 2'b01 gives DEV_WB (default 103079, about 3kHz). 2'b10 gives DEV_BC (default 1717987, about 50kHz). 2'b11 gives 0, so the carrier is streamed unmodulated.
- R8: With mod_en_i low, the carrier word is sent once after reset and once after each change of carrier_word_i, and at no other time. After modulation is switched off, the carrier is sent once if it differs from the last word sent.
- R9: A sample that comes due while a transfer is in progress is dropped. The sample index still advances, so with SAMPLE_DIV=7 only the even indices are sent, every 14 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| carrier_word_i | input | WORD_W | Carrier tuning word |
| dev_mode_i | input | 2 | Deviation mode select |
| mod_en_i | input | 1 | Tone modulation enable |
| dds_data_o | output | 8 | Parallel data byte to the synthesizer |
| dds_wr_o | output | 1 | Byte load strobe |
| dds_fq_ud_o | output | 1 | Frequency update pulse |
| dds_rst_o | output | 1 | Synthesizer reset |

## Verification
The bench runs every deviation mode over twenty samples at three carriers. One carrier sits near zero and one near the top of the word range, so negative and positive offsets wrap. A scaling that truncated toward zero, or an adder of the wrong width, would show up there as an off-by-one or a corrupted high byte. A second instance runs with a sample interval shorter than one transfer. There the bench expects only even sample indices every 14 cycles: a design that aborted a transfer would send broken words, and one that froze the phase index would send sequential indices. The idle-mode tests check for exactly one carrier load per change and for the resend after modulation stops. A design that reloaded all the time, or never reloaded, fails these tests.

// File: rtl/fm_seq_pkg.sv
`timescale 1ns/1ps
package fm_seq_pkg;

  typedef enum logic [1:0] {
    DEV_NARROW = 2'b00,
    DEV_WIDE   = 2'b01,
    DEV_BROAD  = 2'b10,
    DEV_NONE   = 2'b11
  } dev_mode_e;

  localparam int TONE_PTS  = 20;
  localparam int IDX_W     = $clog2(TONE_PTS);
  localparam int SINE_W    = 12;
  localparam int SINE_FRAC = 10;

  // 20-point sine, full scale 1024, built from one quarter wave
  function automatic logic signed [SINE_W-1:0] sine_at(input logic [IDX_W-1:0] k);
    logic [IDX_W-1:0]  r;
    logic [SINE_W-1:0] mag;
    r = (k >= IDX_W'(10)) ? k - IDX_W'(10) : k;
    if (r > IDX_W'(5)) r = IDX_W'(10) - r;
    case (r[2:0])
      3'd0:    mag = 12'd0;
      3'd1:    mag = 12'd316;
      3'd2:    mag = 12'd602;
      3'd3:    mag = 12'd828;
      3'd4:    mag = 12'd974;
      default: mag = 12'd1024;
    endcase
    return (k >= IDX_W'(10)) ? -$signed(mag) : $signed(mag);
  endfunction

endpackage

// File: rtl/fm_tick_gen.sv
`timescale 1ns/1ps
module fm_tick_gen
  import fm_seq_pkg::*;
#(
  parameter int SAMPLE_DIV = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic             tick_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int CNT_W = $clog2(SAMPLE_DIV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  assign tick_o = en_i && (cnt_q == CNT_W'(SAMPLE_DIV - 1));
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      idx_q <= (idx_q == IDX_W'(TONE_PTS - 1)) ? '0 : idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: tone phase restarts at sample 0 whenever modulation is off
  p_phase_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (idx_o == '0));

  // R5: ticks never come back to back
  p_tick_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/fm_word_calc.sv
`timescale 1ns/1ps
module fm_word_calc
  import fm_seq_pkg::*;
#(
  parameter int                WORD_W = 32,
  parameter logic [WORD_W-1:0] DEV_NB = 51540,
  parameter logic [WORD_W-1:0] DEV_WB = 103079,
  parameter logic [WORD_W-1:0] DEV_BC = 1717987
) (
  input  logic [WORD_W-1:0] carrier_i,
  input  dev_mode_e         mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PROD_W = SINE_W + WORD_W + 1;

  logic [WORD_W-1:0]        dev;
  logic signed [SINE_W-1:0] sine_v;
  logic signed [PROD_W-1:0] prod;
  logic                     unused_prod;

  always_comb begin
    unique case (mode_i)
      DEV_NARROW: dev = DEV_NB;
      DEV_WIDE:   dev = DEV_WB;
      DEV_BROAD:  dev = DEV_BC;
      default:    dev = '0;
    endcase
  end

  assign sine_v = sine_at(idx_i);
  assign prod   = sine_v * $signed({1'b0, dev});
  // arithmetic shift: floor of the scaled offset, wraps mod 2^WORD_W
  assign word_o = carrier_i + prod[SINE_FRAC +: WORD_W];
  assign unused_prod = ^{prod[PROD_W-1:SINE_FRAC+WORD_W], prod[SINE_FRAC-1:0]};

endmodule

// File: rtl/fm_byte_loader.sv
`timescale 1ns/1ps
module fm_byte_loader #(
  parameter int         WORD_W    = 32,
  parameter logic [7:0] CTRL_BYTE = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              idle_o,
  output logic [7:0]        data_o,
  output logic              wr_o,
  output logic              fq_ud_o
);
  localparam int N_BYTES = WORD_W / 8 + 1;
  localparam int FRAME_W = 8 * N_BYTES;
  localparam int BCNT_W  = $clog2(N_BYTES);

  typedef enum logic [1:0] {L_IDLE, L_SETUP, L_STROBE, L_UPDATE} lstate_e;

  lstate_e            state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [BCNT_W-1:0]  byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= L_IDLE;
      frame_q <= '0;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        L_IDLE: if (start_i) begin
          frame_q <= {CTRL_BYTE, word_i};
          byte_q  <= '0;
          state_q <= L_SETUP;
        end
        L_SETUP: state_q <= L_STROBE;
        L_STROBE: begin
          if (byte_q == BCNT_W'(N_BYTES - 1)) begin
            state_q <= L_UPDATE;
          end else begin
            byte_q  <= byte_q + 1'b1;
            frame_q <= frame_q << 8;
            state_q <= L_SETUP;
          end
        end
        default: state_q <= L_IDLE;
      endcase
    end
  end

  assign idle_o  = (state_q == L_IDLE);
  assign wr_o    = (state_q == L_STROBE);
  assign fq_ud_o = (state_q == L_UPDATE);
  assign data_o  = (state_q == L_SETUP || state_q == L_STROBE) ? frame_q[FRAME_W-1 -: 8] : 8'h00;

  // R2: byte is already valid the cycle before its strobe
  p_data_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $stable(data_o));

  // R3: update follows the strobe of the last byte
  p_update_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fq_ud_o |-> ($past(wr_o) && $past(byte_q) == BCNT_W'(N_BYTES - 1)));

  // R3: strobe and update are exclusive; update lasts one cycle
  p_exclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fq_ud_o |-> !wr_o);
  p_update_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fq_ud_o |=> !fq_ud_o);

endmodule

// File: rtl/fm_dds_sequencer.sv
`timescale 1ns/1ps
module fm_dds_sequencer
  import fm_seq_pkg::*;
#(
  parameter int                WORD_W     = 32,
  parameter int                SAMPLE_DIV = 10000,
  parameter int                RST_CYCLES = 16,
  parameter logic [7:0]        CTRL_BYTE  = 8'h00,
  parameter logic [WORD_W-1:0] DEV_NB     = 51540,
  parameter logic [WORD_W-1:0] DEV_WB     = 103079,
  parameter logic [WORD_W-1:0] DEV_BC     = 1717987
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] carrier_word_i,
  input  logic [1:0]        dev_mode_i,
  input  logic              mod_en_i,
  output logic [7:0]        dds_data_o,
  output logic              dds_wr_o,
  output logic              dds_fq_ud_o,
  output logic              dds_rst_o
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [RC_W-1:0]   rst_cnt_q;
  logic              tick;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] mod_word, send_word, last_q;
  logic              sent_valid_q, load_idle, load_start;

  // stretched synthesizer reset
  assign dds_rst_o = (rst_cnt_q != RC_W'(RST_CYCLES));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rst_cnt_q <= '0;
    else if (dds_rst_o) rst_cnt_q <= rst_cnt_q + 1'b1;
  end

  fm_tick_gen #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mod_en_i),
    .tick_o (tick),
    .idx_o  (idx)
  );

  fm_word_calc #(
    .WORD_W (WORD_W),
    .DEV_NB (DEV_NB),
    .DEV_WB (DEV_WB),
    .DEV_BC (DEV_BC)
  ) u_calc (
    .carrier_i (carrier_word_i),
    .mode_i    (dev_mode_e'(dev_mode_i)),
    .idx_i     (idx),
    .word_o    (mod_word)
  );

  assign send_word = mod_en_i ? mod_word : carrier_word_i;

  // ticks landing on a busy loader are dropped
  assign load_start = load_idle && !dds_rst_o &&
                      (mod_en_i ? tick : (!sent_valid_q || carrier_word_i != last_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q       <= '0;
      sent_valid_q <= 1'b0;
    end else if (load_start) begin
      last_q       <= send_word;
      sent_valid_q <= 1'b1;
    end
  end

  fm_byte_loader #(
    .WORD_W    (WORD_W),
    .CTRL_BYTE (CTRL_BYTE)
  ) u_load (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (load_start),
    .word_i  (send_word),
    .idle_o  (load_idle),
    .data_o  (dds_data_o),
    .wr_o    (dds_wr_o),
    .fq_ud_o (dds_fq_ud_o)
  );

  // R1: bus quiet while the synthesizer is held in reset
  p_quiet_in_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dds_rst_o |-> (!dds_wr_o && !dds_fq_ud_o));

  // R8: idle mode never starts a load for an already-sent carrier
  p_no_repeat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_en_i && sent_valid_q && $stable(carrier_word_i) && $past(load_idle) && load_idle
     && !$past(mod_en_i)) |-> !load_start);

endmodule

// File: tb/tb_fm_dds_sequencer.sv
`timescale 1ns/1ps
module tb_fm_dds_sequencer;
  localparam int         DIV  = 40;
  localparam int         FDIV = 7;
  localparam int         RSTC = 4;
  localparam logic [7:0] CTRL = 8'h2D;
  localparam longint     DEVS [4] = '{51540, 103079, 1717987, 0};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        rst_n = 1'b0;
  logic [31:0] carrier = 32'h1234_5678, carrier_f = 32'h4000_0000;
  logic [1:0]  mode = 2'b00;
  logic        mod_en = 1'b0, mod_en_f = 1'b0;
  logic [7:0]  data, data_f;
  logic        wr, fq, drst, wr_f, fq_f, drst_f;

  fm_dds_sequencer #(.SAMPLE_DIV(DIV), .RST_CYCLES(RSTC), .CTRL_BYTE(CTRL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .carrier_word_i(carrier), .dev_mode_i(mode),
    .mod_en_i(mod_en), .dds_data_o(data), .dds_wr_o(wr), .dds_fq_ud_o(fq), .dds_rst_o(drst));

  fm_dds_sequencer #(.SAMPLE_DIV(FDIV), .RST_CYCLES(RSTC), .CTRL_BYTE(CTRL)) dut_fast (
    .clk_i(clk), .rst_ni(rst_n), .carrier_word_i(carrier_f), .dev_mode_i(2'b10),
    .mod_en_i(mod_en_f), .dds_data_o(data_f), .dds_wr_o(wr_f), .dds_fq_ud_o(fq_f), .dds_rst_o(drst_f));

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] exp_off(input int m, input int k);
    longint s, p;
    s = longint'(int'(1024.0 * $sin(2.0 * 3.14159265358979 * k / 20.0)));
    p = s * DEVS[m];
    return 32'(p >>> 10);
  endfunction

  // main monitor
  logic        wr_p = 1'b0, fq_p = 1'b0;
  logic [7:0]  d_p = 8'h00;
  logic [39:0] acc = '0;
  int          bcnt = 0, nrx = 0;
  longint      t_first = 0, t_last = 0;
  logic [39:0] rx_w [0:511];
  longint      rx_t [0:511];

  always @(negedge clk) begin
    if (rst_n) begin
      if (drst && (wr || fq)) check(1'b0, "R1 bus active during synth reset", {wr, fq}, 0);
      if (wr && !wr_p) begin
        check(data == d_p, "R2 byte held into strobe", data, d_p);
        if (bcnt == 0) t_first = cyc;
        else check(cyc - t_last == 2, "R4 strobe spacing", cyc - t_last, 2);
        t_last = cyc;
        acc = {acc[31:0], data};
        bcnt++;
      end
      if (wr && wr_p) check(1'b0, "R2 strobe wider than one cycle", 2, 1);
      if (fq) begin
        check(bcnt == 5, "R3 strobes per update", bcnt, 5);
        check(!wr, "R3 update with strobe", wr, 0);
        check(cyc - t_first == 9, "R4 first strobe to update", cyc - t_first, 9);
        if (nrx < 512) begin rx_w[nrx] = acc; rx_t[nrx] = cyc; end
        nrx++;
        bcnt = 0;
      end
      if (fq && fq_p) check(1'b0, "R3 update wider than one cycle", 2, 1);
    end
    wr_p = wr; fq_p = fq; d_p = data;
  end

  // fast-instance monitor
  logic        wrf_p = 1'b0;
  logic [39:0] accf = '0;
  int          nf = 0;
  logic [39:0] rf_w [0:63];
  longint      rf_t [0:63];

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_f && !wrf_p) accf = {accf[31:0], data_f};
      if (fq_f) begin
        if (nf < 64) begin rf_w[nf] = accf; rf_t[nf] = cyc; end
        nf++;
      end
    end
    wrf_p = wr_f;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n, base, fbase;
    logic [31:0] carriers [3];
    logic [31:0] last_w;
    carriers = '{32'h2000_0000, 32'h0000_0400, 32'hFFFF_F800};

    repeat (3) @(negedge clk);
    check(drst && !wr && !fq && data == 8'h00, "R1 outputs during reset",
          {drst, wr, fq, data}, {1'b1, 10'h0});
    check(drst_f && !wr_f && !fq_f, "R1 fast outputs during reset", {drst_f, wr_f, fq_f}, 4);

    @(posedge clk); #1 rst_n = 1'b1;
    n = 0;
    repeat (20) begin @(negedge clk); if (drst) n++; end
    check(n == RSTC, "R1 synth reset hold", n, RSTC);
    cycles(20);

    // R8 idle mode: one carrier load after reset
    check(nrx == 1, "R8 initial carrier load count", nrx, 1);
    check(rx_w[0] == {CTRL, 32'h1234_5678}, "R2 R8 initial word and byte order", rx_w[0], {CTRL, 32'h1234_5678});
    check(nf == 1, "R8 fast initial load", nf, 1);
    cycles(200);
    check(nrx == 1, "R8 no reload of unchanged carrier", nrx, 1);
    carrier = 32'h0ABC_DEF0;
    cycles(30);
    check(nrx == 2, "R8 reload on carrier change", nrx, 2);
    check(rx_w[1] == {CTRL, 32'h0ABC_DEF0}, "R8 changed carrier word", rx_w[1], {CTRL, 32'h0ABC_DEF0});
    carrier = 32'h0ABC_DEF0;
    cycles(100);
    check(nrx == 2, "R8 rewrite of same carrier ignored", nrx, 2);

    // R5 R6 R7 sweep over modes and carriers
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 3; c++) begin
        mode = 2'(m);
        carrier = carriers[c];
        cycles(30);
        base = nrx;
        mod_en = 1'b1;
        cycles(20 * DIV + 15);
        mod_en = 1'b0;
        cycles(30);
        for (int k = 0; k < 20; k++)
          check(rx_w[base + k] == {CTRL, 32'(carriers[c] + exp_off(m, k))},
                $sformatf("R6 R7 mode %0d carrier %0d sample %0d", m, c, k),
                rx_w[base + k], {CTRL, 32'(carriers[c] + exp_off(m, k))});
        for (int k = 1; k < 20; k++)
          check(rx_t[base + k] - rx_t[base + k - 1] == DIV, "R5 sample interval",
                rx_t[base + k] - rx_t[base + k - 1], DIV);
        last_w = 32'(carriers[c] + exp_off(m, 19));
        if (last_w != carriers[c]) begin
          check(nrx == base + 21, "R8 resend after disable count", nrx, base + 21);
          check(rx_w[base + 20] == {CTRL, carriers[c]}, "R8 resend after disable word",
                rx_w[base + 20], {CTRL, carriers[c]});
        end else begin
          check(nrx == base + 20, "R8 no resend when last word is carrier", nrx, base + 20);
        end
      end
    end

    // R9 tick interval shorter than a transfer
    fbase = nf;
    mod_en_f = 1'b1;
    cycles(14 * 12 + 15);
    mod_en_f = 1'b0;
    cycles(30);
    for (int j = 0; j < 10; j++)
      check(rf_w[fbase + j] == {CTRL, 32'(32'h4000_0000 + exp_off(2, (2 * j) % 20))},
            $sformatf("R9 dropped-tick sample %0d", j),
            rf_w[fbase + j], {CTRL, 32'(32'h4000_0000 + exp_off(2, (2 * j) % 20))});
    for (int j = 1; j < 10; j++)
      check(rf_t[fbase + j] - rf_t[fbase + j - 1] == 2 * FDIV, "R9 dropped-tick interval",
            rf_t[fbase + j] - rf_t[fbase + j - 1], 2 * FDIV);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule